// File: doc/BRIEF.md
# Bus-Based 8-bit Accumulator Computer

This block is a minimal stored-program computer in which every register meets on one shared internal data bus. Each clock cycle, exactly one source may place a word on that bus and any number of registers may take it in at the next rising edge. The sources are the program counter, the RAM read port, the address half of the instruction register, the accumulator and the adder-subtracter. A 12-bit control word sets the bus enables and the load strobes. The load strobes are active low. An internal six-step ring sequencer produces that control word from the opcode that the instruction register holds.

To use the block, hold the active-low clear low and write a program and its data into the 16-word RAM through the program-load port. Then release clear. The machine fetches and runs instructions from address 0 until it meets a halt instruction. Results appear on the 8-bit output port. The halted flag then stays high until the next clear.

Arithmetic wraps modulo 256 and no flags are kept. Two parameters choose the implementation variant of the bus multiplexer and of the adder-subtracter.

Top module: `bac_top`

## Requirements
- R1: In every cycle at most one bus source is enabled. Register contents reflect only the single enabled source.
- R2: While `clr_n` is low, `out_port` reads 0 and `halted` reads 0. After `clr_n` is released, execution starts at RAM address 0 with the accumulator at 0.
- R3: Every instruction takes six rising edges. The first three edges fetch the instruction word into the instruction register, and the program counter steps by one modulo 16.
- R4: An instruction word 0000aaaa (LDA) loads the accumulator with RAM word aaaa.
- R5: An instruction word 0001aaaa (ADD) sets the accumulator to acc + RAM[aaaa] modulo 256. An instruction word 0010aaaa (SUB) sets it to acc - RAM[aaaa] modulo 256. The operand passes through the B register.
- R6: An instruction word 1110xxxx (OUT) copies the accumulator to `out_port` on the fourth edge of that instruction. At no other time does `out_port` change.
- R7: An instruction word 1111xxxx (HLT) raises `halted` on the fourth edge of that instruction. For the k-th instruction after clear, this is edge 6(k-1)+4. From then on, `halted` and `out_port` hold until the next clear.
- R8: Opcodes 0011 to 1101 in the upper nibble act as no-operations. They take six edges and leave the accumulator and `out_port` unchanged.
- R9: When `prog_we` is high at a rising edge, `prog_data` is written to RAM word `prog_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers update on its rising edge |
| clr_n | input | 1 | Active-low asynchronous clear of all registers except RAM |
| prog_we | input | 1 | RAM write strobe for program loading |
| prog_addr | input | 4 | RAM word address for program loading |
| prog_data | input | 8 | Word written to RAM |
| out_port | output | 8 | Output register contents |
| halted | output | 1 | High once a halt instruction has executed |

## Verification
The bench builds the block with its defaults: a 4-bit address, an 8-bit data word, the OR-reduction bus and the inverted-operand adder. This configuration is small enough to run a grid of operand pairs through one program that adds and subtracts them. The grid covers 0 and 255 on both sides, so carry-out and borrow wrap-around are reached. Further programs exercise halting on the very first instruction, all eleven no-operation opcodes, and data fetched from a code address. In every run, `out_port` is compared at each edge against an arithmetic model, and the halt edge is checked against its expected count.

// File: rtl/bac_pkg.sv
package bac_pkg;

   localparam int OPC_W = 4;

   localparam logic [OPC_W-1:0] OP_LDA = 4'h0;
   localparam logic [OPC_W-1:0] OP_ADD = 4'h1;
   localparam logic [OPC_W-1:0] OP_SUB = 4'h2;
   localparam logic [OPC_W-1:0] OP_OUT = 4'hE;
   localparam logic [OPC_W-1:0] OP_HLT = 4'hF;

   // Twelve control lines; names ending in _n are active low.
   typedef struct packed {
      logic pc_inc;
      logic pc_drive;
      logic mar_load_n;
      logic ram_drive_n;
      logic ir_load_n;
      logic ir_drive_n;
      logic acc_load_n;
      logic acc_drive;
      logic sub;
      logic alu_drive;
      logic b_load_n;
      logic out_load_n;
   } cw_t;

   localparam cw_t CW_IDLE = '{
      pc_inc: 1'b0, pc_drive: 1'b0, mar_load_n: 1'b1, ram_drive_n: 1'b1,
      ir_load_n: 1'b1, ir_drive_n: 1'b1, acc_load_n: 1'b1, acc_drive: 1'b0,
      sub: 1'b0, alu_drive: 1'b0, b_load_n: 1'b1, out_load_n: 1'b1};

endpackage

// File: rtl/bac_ram.sv
module bac_ram #(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/bac_addsub.sv
module bac_addsub #(
   parameter int DATA_W = 8,
   parameter int STYLE  = 0   // 0: inverted operand plus carry-in, 1: separate add and subtract
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              sub,
   output logic [DATA_W-1:0] y
);
   if (STYLE != 0 && STYLE != 1) begin : g_bad_style
      $error("bac_addsub: STYLE must be 0 or 1");
   end

   if (STYLE == 0) begin : g_inv
      assign y = a + (b ^ {DATA_W{sub}}) + {{(DATA_W-1){1'b0}}, sub};
   end else begin : g_split
      assign y = sub ? (a - b) : (a + b);
   end
endmodule

// File: rtl/bac_seq.sv
module bac_seq
   import bac_pkg::*;
(
   input  logic             clk,
   input  logic             clr_n,
   input  logic [OPC_W-1:0] opcode,
   output cw_t              cw,
   output logic             halted
);
   localparam int T_N = 6;

   logic [T_N-1:0] t;
   logic           mem_op;

   assign mem_op = (opcode == OP_LDA) || (opcode == OP_ADD) || (opcode == OP_SUB);

   always_ff @(posedge clk or negedge clr_n) begin
      if (!clr_n) begin
         t      <= {{(T_N-1){1'b0}}, 1'b1};
         halted <= 1'b0;
      end else if (!halted) begin
         t <= {t[T_N-2:0], t[T_N-1]};
         if (t[3] && opcode == OP_HLT) halted <= 1'b1;
      end
   end

   always_comb begin
      cw = CW_IDLE;
      if (!halted) begin
         if (t[0]) begin
            cw.pc_drive   = 1'b1;
            cw.mar_load_n = 1'b0;
         end else if (t[1]) begin
            cw.pc_inc = 1'b1;
         end else if (t[2]) begin
            cw.ram_drive_n = 1'b0;
            cw.ir_load_n   = 1'b0;
         end else if (t[3]) begin
            if (mem_op) begin
               cw.ir_drive_n = 1'b0;
               cw.mar_load_n = 1'b0;
            end else if (opcode == OP_OUT) begin
               cw.acc_drive  = 1'b1;
               cw.out_load_n = 1'b0;
            end
         end else if (t[4]) begin
            if (opcode == OP_LDA) begin
               cw.ram_drive_n = 1'b0;
               cw.acc_load_n  = 1'b0;
            end else if (opcode == OP_ADD || opcode == OP_SUB) begin
               cw.ram_drive_n = 1'b0;
               cw.b_load_n    = 1'b0;
            end
         end else if (t[5]) begin
            if (opcode == OP_ADD || opcode == OP_SUB) begin
               cw.alu_drive  = 1'b1;
               cw.acc_load_n = 1'b0;
               cw.sub        = (opcode == OP_SUB);
            end
         end
      end
   end

   // R3: the step ring always holds exactly one active step
   a_r3_ring_onehot: assert property (@(posedge clk) disable iff (!clr_n)
      $onehot(t));

   // R7: once halted, the machine stays halted and the step ring freezes
   a_r7_halt_sticky: assert property (@(posedge clk) disable iff (!clr_n)
      halted |=> (halted && $stable(t)));
endmodule

// File: rtl/bac_datapath.sv
module bac_datapath
   import bac_pkg::*;
#(
   parameter int ADDR_W    = 4,
   parameter int DATA_W    = 8,
   parameter bit BUS_OR    = 1'b1,
   parameter int ADD_STYLE = 0
) (
   input  logic              clk,
   input  logic              clr_n,
   input  cw_t               cw,
   input  logic              prog_we,
   input  logic [ADDR_W-1:0] prog_addr,
   input  logic [DATA_W-1:0] prog_data,
   output logic [OPC_W-1:0]  opcode,
   output logic [DATA_W-1:0] out_q
);
   localparam int N_SRC = 5;
   localparam int S_PC  = 0;
   localparam int S_RAM = 1;
   localparam int S_IR  = 2;
   localparam int S_ACC = 3;
   localparam int S_ALU = 4;
   localparam int PAD_W = DATA_W - ADDR_W;

   logic [ADDR_W-1:0] pc, mar;
   logic [DATA_W-1:0] ir, acc, breg, ram_rd, alu_y, bus;
   logic [N_SRC-1:0]  drv_en;
   logic [DATA_W-1:0] drv_val [N_SRC];

   bac_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
      .clk  (clk),
      .we   (prog_we),
      .waddr(prog_addr),
      .wdata(prog_data),
      .raddr(mar),
      .rdata(ram_rd)
   );

   bac_addsub #(.DATA_W(DATA_W), .STYLE(ADD_STYLE)) u_alu (
      .a  (acc),
      .b  (breg),
      .sub(cw.sub),
      .y  (alu_y)
   );

   // Bus sources
   assign drv_en[S_PC]  = cw.pc_drive;
   assign drv_en[S_RAM] = !cw.ram_drive_n;
   assign drv_en[S_IR]  = !cw.ir_drive_n;
   assign drv_en[S_ACC] = cw.acc_drive;
   assign drv_en[S_ALU] = cw.alu_drive;

   assign drv_val[S_PC]  = {{PAD_W{1'b0}}, pc};
   assign drv_val[S_RAM] = ram_rd;
   assign drv_val[S_IR]  = {{PAD_W{1'b0}}, ir[ADDR_W-1:0]};
   assign drv_val[S_ACC] = acc;
   assign drv_val[S_ALU] = alu_y;

   // An undriven bus reads as zero in both variants
   if (BUS_OR) begin : g_bus_or
      always_comb begin
         bus = '0;
         for (int i = 0; i < N_SRC; i++) bus |= drv_val[i] & {DATA_W{drv_en[i]}};
      end
   end else begin : g_bus_pri
      always_comb begin
         bus = '0;
         for (int i = N_SRC - 1; i >= 0; i--) if (drv_en[i]) bus = drv_val[i];
      end
   end

   always_ff @(posedge clk or negedge clr_n) begin
      if (!clr_n) begin
         pc    <= '0;
         mar   <= '0;
         ir    <= '0;
         acc   <= '0;
         breg  <= '0;
         out_q <= '0;
      end else begin
         if (cw.pc_inc)                      pc    <= pc + 1'b1;
         if (!cw.mar_load_n)                 mar   <= bus[ADDR_W-1:0];
         if (!cw.ir_load_n)                  ir    <= bus;
         if (!cw.acc_load_n)                 acc   <= bus;
         if (!cw.b_load_n)                   breg  <= bus;
         if (cw.acc_drive && !cw.out_load_n) out_q <= bus;
      end
   end

   assign opcode = ir[DATA_W-1:ADDR_W];

   // R1: never more than one source on the bus
   a_r1_one_driver: assert property (@(posedge clk) disable iff (!clr_n)
      $onehot0(drv_en));

   // R3: program counter steps by one when told to
   a_r3_pc_step: assert property (@(posedge clk) disable iff (!clr_n)
      cw.pc_inc |=> (pc == $past(pc) + 1'b1));

   // R5: B register captures the bus word
   a_r5_b_load: assert property (@(posedge clk) disable iff (!clr_n)
      !cw.b_load_n |=> (breg == $past(bus)));

   // R6: output register takes the accumulator word
   a_r6_out_load: assert property (@(posedge clk) disable iff (!clr_n)
      (cw.acc_drive && !cw.out_load_n) |=> (out_q == $past(acc)));

   // R6: output register holds otherwise
   a_r6_out_hold: assert property (@(posedge clk) disable iff (!clr_n)
      !(cw.acc_drive && !cw.out_load_n) |=> $stable(out_q));
endmodule

// File: rtl/bac_top.sv
module bac_top
   import bac_pkg::*;
#(
   parameter int ADDR_W    = 4,
   parameter int DATA_W    = 8,
   parameter bit BUS_OR    = 1'b1,
   parameter int ADD_STYLE = 0
) (
   input  logic              clk,
   input  logic              clr_n,
   input  logic              prog_we,
   input  logic [ADDR_W-1:0] prog_addr,
   input  logic [DATA_W-1:0] prog_data,
   output logic [DATA_W-1:0] out_port,
   output logic              halted
);
   if (DATA_W != ADDR_W + OPC_W) begin : g_bad_width
      $error("bac_top: DATA_W must equal ADDR_W plus the opcode width");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("bac_top: ADDR_W must be at least 1");
   end

   cw_t              cw;
   logic [OPC_W-1:0] opcode;

   bac_seq u_seq (
      .clk   (clk),
      .clr_n (clr_n),
      .opcode(opcode),
      .cw    (cw),
      .halted(halted)
   );

   bac_datapath #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .BUS_OR   (BUS_OR),
      .ADD_STYLE(ADD_STYLE)
   ) u_dp (
      .clk      (clk),
      .clr_n    (clr_n),
      .cw       (cw),
      .prog_we  (prog_we),
      .prog_addr(prog_addr),
      .prog_data(prog_data),
      .opcode   (opcode),
      .out_q    (out_port)
   );
endmodule

// File: tb/sim_bac_top.sv
module sim_bac_top;
   localparam int MAXE = 128;

   logic       clk = 1'b0;
   logic       clr_n = 1'b0;
   logic       prog_we = 1'b0;
   logic [3:0] prog_addr = '0;
   logic [7:0] prog_data = '0;
   logic [7:0] out_port;
   logic       halted;

   int n_checks = 0;
   int n_fail   = 0;
   int cyc      = 0;

   logic [7:0] img [16];
   logic [7:0] exp_out [MAXE];
   int         exp_halt;

   bac_top u0 (
      .clk      (clk),
      .clr_n    (clr_n),
      .prog_we  (prog_we),
      .prog_addr(prog_addr),
      .prog_data(prog_data),
      .out_port (out_port),
      .halted   (halted)
   );

   always #2 clk = ~clk;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         n_fail++;
         n_checks++;
         $display("FAIL watchdog: run did not finish, cycles %0d expected below 150000", cyc);
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Reference model: per-edge expected output and the halt edge
   task automatic model();
      logic [3:0] pc = '0;
      logic [7:0] acc = '0;
      logic [7:0] outv = '0;
      logic [7:0] m [16];
      int e = 0;
      for (int i = 0; i < 16; i++) m[i] = img[i];
      for (int i = 0; i < MAXE; i++) exp_out[i] = 8'h00;
      exp_halt = -1;
      for (int k = 0; k < 20; k++) begin
         logic [7:0] ins = m[pc];
         logic [3:0] op = ins[7:4];
         logic [3:0] ad = ins[3:0];
         pc = pc + 4'd1;
         if (op == 4'hF) begin
            exp_halt = e + 4;
            for (int j = e + 1; j < MAXE; j++) exp_out[j] = outv;
            break;
         end
         for (int j = 1; j <= 6; j++)
            exp_out[e + j] = (op == 4'hE && j >= 4) ? acc : outv;
         case (op)
            4'h0: acc = m[ad];
            4'h1: acc = acc + m[ad];
            4'h2: acc = acc - m[ad];
            4'hE: outv = acc;
            default: ;
         endcase
         e += 6;
      end
   endtask

   // R9: program words go in through the load port while clear is held
   task automatic load_prog();
      clr_n = 1'b0;
      for (int i = 0; i < 16; i++) begin
         @(negedge clk);
         prog_we   = 1'b1;
         prog_addr = 4'(i);
         prog_data = img[i];
      end
      @(negedge clk);
      prog_we = 1'b0;
   endtask

   task automatic run(input string tag);
      int  halt_at = -1;
      bit  trace_ok = 1'b1;
      int  bad_e = 0;
      logic [7:0] bad_v = '0;
      logic [7:0] held;
      model();
      load_prog();
      check(out_port == 8'h00 && halted == 1'b0, {tag, " R2 clear state"},
            int'({halted, out_port}), 0);
      @(negedge clk);
      clr_n = 1'b1;
      for (int e = 1; e <= exp_halt + 2 && e < MAXE - 1; e++) begin
         @(posedge clk);
         #1;
         if (halted && halt_at < 0) halt_at = e;
         if (trace_ok && out_port != exp_out[e]) begin
            trace_ok = 1'b0;
            bad_e = e;
            bad_v = out_port;
         end
      end
      check(trace_ok, {tag, " R1,R4,R5,R6,R8,R9 output trace"}, int'(bad_v),
            int'(exp_out[bad_e]));
      check(halt_at == exp_halt, {tag, " R3,R7 halt edge"}, halt_at, exp_halt);
      held = out_port;
      repeat (8) @(posedge clk);
      #1;
      check(halted == 1'b1 && out_port == held, {tag, " R7 frozen after halt"},
            int'(out_port), int'(held));
   endtask

   initial begin
      // Operand grid: ADD then two SUBs, two OUTs (R4, R5, R6)
      for (int ia = 0; ia < 18; ia++) begin
         for (int ib = 0; ib < 25; ib++) begin
            for (int i = 0; i < 16; i++) img[i] = 8'h00;
            img[0]  = 8'h0E;  // LDA 14
            img[1]  = 8'h1F;  // ADD 15
            img[2]  = 8'hE0;  // OUT
            img[3]  = 8'h2F;  // SUB 15
            img[4]  = 8'h2F;  // SUB 15
            img[5]  = 8'hE0;  // OUT
            img[6]  = 8'hF0;  // HLT
            img[14] = 8'(ia * 15);
            img[15] = (ib == 24) ? 8'hFF : 8'(ib * 11);
            run("grid");
         end
      end

      // R7: halt as the very first instruction, output stays 0
      for (int i = 0; i < 16; i++) img[i] = 8'h00;
      img[0] = 8'hF3;
      img[1] = 8'hE0;
      run("halt_first");

      // R8: all no-operation opcodes between a load and an output
      for (int i = 0; i < 16; i++) img[i] = 8'h00;
      img[0] = 8'h0E;
      for (int i = 1; i <= 11; i++) img[i] = {4'(i + 2), 4'(i)};
      img[12] = 8'hE0;
      img[13] = 8'hF0;
      img[14] = 8'hA7;
      run("nop_sweep");

      // R4: data read from a code address, then accumulated onto itself
      for (int i = 0; i < 16; i++) img[i] = 8'h00;
      img[0] = 8'h03;
      img[1] = 8'hE0;
      img[2] = 8'h10;  // ADD 0: adds the word 0x03
      img[3] = 8'hE0;
      img[4] = 8'hF0;
      run("code_data");

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule